// File: doc/BRIEF.md
# Addressable LED frame sequencer

This block runs one frame of pixel transfers towards a chain of single-wire RGB LEDs. Pixel words enter a small on-block FIFO, either written by software or pushed by a DMA channel that the block requests. Once started, the sequencer pops one word at a time and offers it to a separate bit-waveform encoder through a valid/ready handshake. It counts the handed-off pixels against a programmed frame length. Between pixels it can hold off for a programmable gap. After the last pixel it drives a line-latch interval and then an optional long inter-frame gap.

All durations are measured in ticks. One tick is `TICK_DIV` clock cycles, and a programmed value N lasts N+1 ticks. The block also watches for the FIFO starving in the middle of a frame. It flags a write into a full FIFO, asks for refill when the FIFO runs low, and reports all of this through write-one-to-clear status bits and a single interrupt line. A soft-reset input aborts any frame and empties the FIFO. Configuration arrives as plain inputs rather than through a register bus.

Top module: `ledframe_seq`

## Requirements
- R1: After reset, `active_o`, `pix_valid_o`, `line_latch_o`, `irq_o`, `dma_req_o` and every bit of `sts_o` are 0.
- R2: A pulse on `go_i` while idle hands exactly the programmed number of pixels to the encoder, in FIFO write order. `active_o` then returns to 0 by itself. While `pix_ready_i` is low, `pix_valid_o` and `pix_data_o` hold.
- R3: A length write (`len_wr_i`) with value 0 is ignored, and the previous length stays in force. The length after reset is 1.
- R4: With `pgap_en_i` set, a gap of `pgap_n_i`+1 ticks follows each non-last handshake, so handshakes with data ready and `pix_ready_i` high are `pgap_n_i`+3 cycles apart (TICK_DIV=1). With the gap off they are 2 cycles apart.
- R5: With `latch_en_i` set, `line_latch_o` is high for exactly `latch_n_i`+1 ticks, starting right after the last handshake. With the latch off it never rises.
- R6: The done status (`sts_o[0]`) is set in the cycle the latch interval ends, or at the last handshake when the latch is off.
- R7: With `fgap_en_i` set, `active_o` stays high for `fgap_n_i`+1 ticks after done is set. With the gap off it falls in the same cycle.
- R8: If the FIFO is empty while a pixel is due for `wait_n_i`+1 ticks, the starve status (`sts_o[1]`) is set. With TICK_DIV=1 it is visible `wait_n_i`+2 cycles after the cycle in which `go_i` is raised.
- R9: A write into a full FIFO (`DEPTH` words) is dropped and sets the overflow status (`sts_o[2]`). The dropped word is never sent.
- R10: Refill is wanted while a frame is active, the FIFO holds `DEPTH`/2 words or fewer, and more pixels remain to be popped than are stored. In CPU mode (`dma_mode_i`=0) this sets `sts_o[3]`. In DMA mode it drives `dma_req_o` and leaves `sts_o[3]` alone.
- R11: Writing 1 to a bit of `sts_clr_i` clears that status bit. A set event in the same cycle wins.
- R12: `irq_o` is high only when `irq_glob_en_i` is 1 and some status bit is set with its `irq_mask_i` bit (same position) set.
- R13: `soft_rst_i` returns the block to idle in the next cycle, drops any frame and empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Abort frame, flush FIFO |
| go_i | input | 1 | Start a frame when idle |
| len_wr_i | input | 1 | Load frame length |
| len_i | input | LEN_W | Frame length in pixels (0 ignored) |
| latch_en_i | input | 1 | Enable latch interval |
| latch_n_i | input | LATCH_W | Latch interval, N+1 ticks |
| pgap_en_i | input | 1 | Enable inter-pixel gap |
| pgap_n_i | input | PGAP_W | Inter-pixel gap, N+1 ticks |
| fgap_en_i | input | 1 | Enable inter-frame gap |
| fgap_n_i | input | FGAP_W | Inter-frame gap, N+1 ticks |
| wait_n_i | input | WAIT_W | Starve limit, N+1 ticks |
| dma_mode_i | input | 1 | 1: DMA refill, 0: CPU refill |
| irq_mask_i | input | 4 | Per-status interrupt enables |
| irq_glob_en_i | input | 1 | Global interrupt enable |
| sts_clr_i | input | 4 | Write-one-to-clear strobes |
| wr_valid_i | input | 1 | FIFO write strobe |
| wr_data_i | input | DATA_W | FIFO write word |
| pix_valid_o | output | 1 | Pixel offered to encoder |
| pix_data_o | output | DATA_W | Pixel word |
| pix_ready_i | input | 1 | Encoder accepts pixel |
| line_latch_o | output | 1 | Latch interval in progress |
| active_o | output | 1 | Frame in progress (self-clearing enable) |
| sts_o | output | 4 | Status: 0 done, 1 starve, 2 overflow, 3 refill |
| irq_o | output | 1 | Interrupt |
| dma_req_o | output | 1 | DMA refill request |

## Verification
The overflow event and a write-one-to-clear of the same status bit can land in one clock. The bench fills the FIFO to its depth, then drives one more write together with a clear strobe for the overflow bit in the same cycle. It expects the bit still set afterwards, and cleared only after a clear strobe alone. Gap, latch, inter-frame and starve durations are swept over several values, and each measured cycle count is compared with N plus a fixed pipeline offset worked out from the handshake timing.

// File: rtl/ledframe_pkg.sv
package ledframe_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_LOAD, ST_SEND, ST_PGAP, ST_LATCH, ST_FGAP
   } seq_state_t;

   localparam int SB_DONE   = 0;
   localparam int SB_STARVE = 1;
   localparam int SB_OVF    = 2;
   localparam int SB_REFILL = 3;
   localparam int SB_COUNT  = 4;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ledframe_tick.sv
module ledframe_tick #(
   parameter int TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt <= '0;
            else if (cnt == DW'(TICK_DIV - 1)) cnt <= '0;
            else                               cnt <= cnt + DW'(1);
         end
         assign tick = (cnt == DW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/ledframe_fifo.sv
module ledframe_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic [LVL_W-1:0]  level,
   output logic              ovf_ev
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              full, push, take;

   assign full   = (level == LVL_W'(DEPTH));
   assign empty  = (level == '0);
   assign push   = wr && !full && !flush;
   assign take   = pop && !empty && !flush;
   assign ovf_ev = wr && full;
   assign rdata  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (take) rd_ptr <= rd_ptr + PTR_W'(1);
         case ({push, take})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ledframe_status.sv
module ledframe_status #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] ev,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] mask,
   input  logic            glob,
   output logic [NSRC-1:0] sts,
   output logic            irq
);
   logic [NSRC-1:0] hit;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sts[i] <= 1'b0;
            else if (ev[i]) sts[i] <= 1'b1;
            else if (clr[i]) sts[i] <= 1'b0;
         end
         assign hit[i] = sts[i] & mask[i];
      end
   endgenerate

   assign irq = glob & (|hit);
endmodule

// File: rtl/ledframe_ctrl.sv
module ledframe_ctrl
   import ledframe_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 13,
   parameter int LATCH_W = 13,
   parameter int PGAP_W  = 8,
   parameter int FGAP_W  = 31,
   parameter int WAIT_W  = 13,
   parameter int LVL_W   = 6,
   parameter int HALF    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               soft_rst,
   input  logic               go,
   input  logic               len_wr,
   input  logic [LEN_W-1:0]   len_val,
   input  logic               latch_en,
   input  logic [LATCH_W-1:0] latch_n,
   input  logic               pgap_en,
   input  logic [PGAP_W-1:0]  pgap_n,
   input  logic               fgap_en,
   input  logic [FGAP_W-1:0]  fgap_n,
   input  logic [WAIT_W-1:0]  wait_n,
   input  logic               fifo_empty,
   input  logic [DATA_W-1:0]  fifo_rdata,
   input  logic [LVL_W-1:0]   fifo_level,
   input  logic               pix_ready,
   output logic               fifo_pop,
   output logic               pix_valid,
   output logic [DATA_W-1:0]  pix_data,
   output logic               line_latch,
   output logic               active,
   output logic               ev_finish,
   output logic               ev_timeout,
   output logic               refill_cond
);
   localparam int CNT_W = max_i(max_i(LATCH_W, PGAP_W), FGAP_W);
   localparam int CMP_W = max_i(LEN_W, LVL_W) + 1;

   seq_state_t         st;
   logic [LEN_W-1:0]   len_q, left_q;
   logic [CNT_W-1:0]   dcnt, dlim;
   logic [WAIT_W-1:0]  wcnt;
   logic               starve_seen;
   logic [DATA_W-1:0]  pix_q;
   logic               dur_done, hs, last_hs;
   logic [CMP_W-1:0]   pend;

   always_comb begin
      case (st)
         ST_PGAP:  dlim = CNT_W'(pgap_n);
         ST_LATCH: dlim = CNT_W'(latch_n);
         default:  dlim = CNT_W'(fgap_n);
      endcase
   end

   assign dur_done    = tick && (dcnt == dlim);
   assign hs          = (st == ST_SEND) && pix_ready;
   assign last_hs     = hs && (left_q == LEN_W'(1));
   assign fifo_pop    = (st == ST_LOAD) && !fifo_empty && !soft_rst;
   assign pend        = CMP_W'(left_q) - CMP_W'(st == ST_SEND);
   assign refill_cond = (st == ST_LOAD || st == ST_SEND || st == ST_PGAP) &&
                        (pend > CMP_W'(fifo_level)) &&
                        (fifo_level <= LVL_W'(HALF));
   assign ev_timeout  = !soft_rst && (st == ST_LOAD) && fifo_empty && tick &&
                        !starve_seen && (wcnt == wait_n);
   assign ev_finish   = !soft_rst && ((last_hs && !latch_en) ||
                                      ((st == ST_LATCH) && dur_done));
   assign line_latch  = (st == ST_LATCH);
   assign active      = (st != ST_IDLE);
   assign pix_valid   = (st == ST_SEND);
   assign pix_data    = pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           len_q <= LEN_W'(1);
      else if (len_wr && len_val != '0)     len_q <= len_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         left_q      <= '0;
         dcnt        <= '0;
         wcnt        <= '0;
         starve_seen <= 1'b0;
         pix_q       <= '0;
      end else if (soft_rst) begin
         st          <= ST_IDLE;
         left_q      <= '0;
         dcnt        <= '0;
         wcnt        <= '0;
         starve_seen <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (go) begin
               st          <= ST_LOAD;
               left_q      <= len_q;
               wcnt        <= '0;
               starve_seen <= 1'b0;
            end
            ST_LOAD: begin
               if (!fifo_empty) begin
                  pix_q <= fifo_rdata;
                  st    <= ST_SEND;
               end else if (tick && !starve_seen) begin
                  if (wcnt == wait_n) starve_seen <= 1'b1;
                  else                wcnt        <= wcnt + WAIT_W'(1);
               end
            end
            ST_SEND: if (pix_ready) begin
               left_q      <= left_q - LEN_W'(1);
               dcnt        <= '0;
               wcnt        <= '0;
               starve_seen <= 1'b0;
               if (left_q == LEN_W'(1))
                  st <= latch_en ? ST_LATCH : (fgap_en ? ST_FGAP : ST_IDLE);
               else
                  st <= pgap_en ? ST_PGAP : ST_LOAD;
            end
            ST_PGAP, ST_LATCH, ST_FGAP: begin
               if (dur_done) begin
                  dcnt <= '0;
                  if (st == ST_PGAP)       st <= ST_LOAD;
                  else if (st == ST_LATCH) st <= fgap_en ? ST_FGAP : ST_IDLE;
                  else                     st <= ST_IDLE;
               end else if (tick) begin
                  dcnt <= dcnt + CNT_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ledframe_seq.sv
module ledframe_seq
   import ledframe_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 32,
   parameter int LEN_W    = 13,
   parameter int LATCH_W  = 13,
   parameter int PGAP_W   = 8,
   parameter int FGAP_W   = 31,
   parameter int WAIT_W   = 13,
   parameter int TICK_DIV = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst_i,
   input  logic                go_i,
   input  logic                len_wr_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic                latch_en_i,
   input  logic [LATCH_W-1:0]  latch_n_i,
   input  logic                pgap_en_i,
   input  logic [PGAP_W-1:0]   pgap_n_i,
   input  logic                fgap_en_i,
   input  logic [FGAP_W-1:0]   fgap_n_i,
   input  logic [WAIT_W-1:0]   wait_n_i,
   input  logic                dma_mode_i,
   input  logic [SB_COUNT-1:0] irq_mask_i,
   input  logic                irq_glob_en_i,
   input  logic [SB_COUNT-1:0] sts_clr_i,
   input  logic                wr_valid_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic                pix_valid_o,
   output logic [DATA_W-1:0]   pix_data_o,
   input  logic                pix_ready_i,
   output logic                line_latch_o,
   output logic                active_o,
   output logic [SB_COUNT-1:0] sts_o,
   output logic                irq_o,
   output logic                dma_req_o
);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int HALF  = DEPTH / 2;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ledframe_seq: DEPTH must be a power of two of at least 4");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("ledframe_seq: TICK_DIV must be at least 1");
      end
      if (FGAP_W > 31 || LEN_W < 1) begin : g_bad_width
         $error("ledframe_seq: unsupported counter width");
      end
   endgenerate

   logic              tick;
   logic              fifo_pop, fifo_empty, ovf_ev;
   logic [DATA_W-1:0] fifo_rdata;
   logic [LVL_W-1:0]  fifo_level;
   logic              ev_finish, ev_timeout, refill_cond;
   logic [SB_COUNT-1:0] ev;

   ledframe_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   ledframe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst_i),
      .wr(wr_valid_i), .wdata(wr_data_i), .pop(fifo_pop),
      .rdata(fifo_rdata), .empty(fifo_empty), .level(fifo_level),
      .ovf_ev(ovf_ev)
   );

   ledframe_ctrl #(
      .DATA_W(DATA_W), .LEN_W(LEN_W), .LATCH_W(LATCH_W), .PGAP_W(PGAP_W),
      .FGAP_W(FGAP_W), .WAIT_W(WAIT_W), .LVL_W(LVL_W), .HALF(HALF)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .soft_rst(soft_rst_i),
      .go(go_i), .len_wr(len_wr_i), .len_val(len_i),
      .latch_en(latch_en_i), .latch_n(latch_n_i),
      .pgap_en(pgap_en_i), .pgap_n(pgap_n_i),
      .fgap_en(fgap_en_i), .fgap_n(fgap_n_i), .wait_n(wait_n_i),
      .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
      .fifo_level(fifo_level), .pix_ready(pix_ready_i),
      .fifo_pop(fifo_pop), .pix_valid(pix_valid_o), .pix_data(pix_data_o),
      .line_latch(line_latch_o), .active(active_o),
      .ev_finish(ev_finish), .ev_timeout(ev_timeout),
      .refill_cond(refill_cond)
   );

   always_comb begin
      ev            = '0;
      ev[SB_DONE]   = ev_finish;
      ev[SB_STARVE] = ev_timeout;
      ev[SB_OVF]    = ovf_ev;
      ev[SB_REFILL] = refill_cond && !dma_mode_i;
   end

   assign dma_req_o = refill_cond && dma_mode_i;

   ledframe_status #(.NSRC(SB_COUNT)) u_status (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(sts_clr_i),
      .mask(irq_mask_i), .glob(irq_glob_en_i), .sts(sts_o), .irq(irq_o)
   );
endmodule

// File: rtl/ledframe_seq_chk.sv
module ledframe_seq_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int LVL_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst_i,
   input logic              wr_valid_i,
   input logic              dma_mode_i,
   input logic              irq_glob_en_i,
   input logic              pix_valid_o,
   input logic [DATA_W-1:0] pix_data_o,
   input logic              pix_ready_i,
   input logic              line_latch_o,
   input logic              active_o,
   input logic [3:0]        sts_o,
   input logic              irq_o,
   input logic              dma_req_o,
   input logic [LVL_W-1:0]  fifo_level
);
   a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_o && !pix_ready_i && !soft_rst_i |=> pix_valid_o && $stable(pix_data_o));

   a_r5_latch_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_latch_o) |-> $past(pix_valid_o && pix_ready_i));

   a_r6_done_at_latch_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_latch_o) && !$past(soft_rst_i) |-> sts_o[0]);

   a_r9_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_i && (fifo_level == LVL_W'(DEPTH)) |=> sts_o[2]);

   a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH));

   a_r10_cpu_only_refill: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_o[3]) |-> $past(!dma_mode_i));

   a_r10_dma_req_mode: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> dma_mode_i && active_o);

   a_r12_glob_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_glob_en_i |-> !irq_o);

   a_r13_softrst_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> !active_o && (fifo_level == '0));
endmodule

bind ledframe_seq ledframe_seq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .wr_valid_i(wr_valid_i),
   .dma_mode_i(dma_mode_i), .irq_glob_en_i(irq_glob_en_i),
   .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .pix_ready_i(pix_ready_i),
   .line_latch_o(line_latch_o), .active_o(active_o), .sts_o(sts_o),
   .irq_o(irq_o), .dma_req_o(dma_req_o), .fifo_level(fifo_level)
);

// File: tb/ledframe_seq_bench.sv
module ledframe_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst_i = 0, go_i = 0, len_wr_i = 0;
   logic [12:0] len_i = 0;
   logic        latch_en_i = 0, pgap_en_i = 0, fgap_en_i = 0;
   logic [12:0] latch_n_i = 0;
   logic [7:0]  pgap_n_i = 0;
   logic [30:0] fgap_n_i = 0;
   logic [12:0] wait_n_i = 13'h1FFF;
   logic        dma_mode_i = 0, irq_glob_en_i = 0, wr_valid_i = 0;
   logic [3:0]  irq_mask_i = 0, sts_clr_i = 0;
   logic [31:0] wr_data_i = 0;
   logic        pix_ready_i = 1;
   logic        pix_valid_o, line_latch_o, active_o, irq_o, dma_req_o;
   logic [31:0] pix_data_o;
   logic [3:0]  sts_o;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic        mon_clr = 0;
   int          hs_cnt = 0, lat_cnt = 0, fg_cnt = 0, to_cyc = 0, go_set = 0;
   bit          dreq_seen = 0;
   logic [31:0] hs_data [64];
   int          hs_cyc  [64];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ledframe_seq u_ledframe_seq (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .go_i(go_i),
      .len_wr_i(len_wr_i), .len_i(len_i), .latch_en_i(latch_en_i),
      .latch_n_i(latch_n_i), .pgap_en_i(pgap_en_i), .pgap_n_i(pgap_n_i),
      .fgap_en_i(fgap_en_i), .fgap_n_i(fgap_n_i), .wait_n_i(wait_n_i),
      .dma_mode_i(dma_mode_i), .irq_mask_i(irq_mask_i),
      .irq_glob_en_i(irq_glob_en_i), .sts_clr_i(sts_clr_i),
      .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
      .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o),
      .pix_ready_i(pix_ready_i), .line_latch_o(line_latch_o),
      .active_o(active_o), .sts_o(sts_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
   );

   always @(negedge clk) begin
      if (mon_clr) begin
         hs_cnt = 0; lat_cnt = 0; fg_cnt = 0; to_cyc = 0; dreq_seen = 0;
      end else begin
         if (pix_valid_o && pix_ready_i && hs_cnt < 64) begin
            hs_data[hs_cnt] = pix_data_o;
            hs_cyc[hs_cnt]  = cyc;
            hs_cnt++;
         end
         if (line_latch_o) lat_cnt++;
         if (active_o && sts_o[0]) fg_cnt++;
         if (sts_o[1] && to_cyc == 0) to_cyc = cyc;
         if (dma_req_o) dreq_seen = 1;
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] d);
      wr_valid_i = 1; wr_data_i = d; step(); wr_valid_i = 0;
   endtask

   task automatic set_len(input int len);
      len_i = 13'(len); len_wr_i = 1; step(); len_wr_i = 0;
   endtask

   task automatic pulse_soft();
      soft_rst_i = 1; step(); soft_rst_i = 0;
   endtask

   task automatic go_frame();
      sts_clr_i = 4'hF; step(); sts_clr_i = 0;
      mon_clr = 1; step(); mon_clr = 0;
      go_i = 1; go_set = cyc; step(); go_i = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (!active_o) break;
      end
      step();
   endtask

   task automatic frame(input int len, input logic [31:0] base);
      set_len(len);
      for (int k = 0; k < len; k++) push(base + 32'(k));
      go_frame();
      wait_idle();
   endtask

   task automatic check_data(input int len, input logic [31:0] base, input string tag);
      int mism = 0;
      chk(hs_cnt == len, {tag, " pixel count"}, hs_cnt, len);
      for (int k = 0; k < len && k < hs_cnt; k++)
         if (hs_data[k] !== base + 32'(k)) mism++;
      chk(mism == 0, {tag, " pixel order"}, mism, 0);
   endtask

   task automatic check_spacing(input int exp, input string tag);
      int off = 0;
      for (int k = 1; k < hs_cnt; k++)
         if (hs_cyc[k] - hs_cyc[k-1] != exp) off++;
      chk(off == 0, tag, off, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic seen;
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      chk(!active_o && !pix_valid_o && !line_latch_o, "R1 idle outputs", active_o, 0);
      chk(sts_o == 0 && !irq_o && !dma_req_o, "R1 status clear", sts_o, 0);

      // R2 lengths 1..6, no gaps, no latch
      for (int len = 1; len <= 6; len++) begin
         frame(len, 32'h1000 * len);
         check_data(len, 32'h1000 * len, "R2");
         chk(!active_o, "R2 self clear", active_o, 0);
         check_spacing(2, "R4 no gap spacing");
         chk(sts_o[0] == 1'b1, "R6 done without latch", sts_o[0], 1);
         chk(lat_cnt == 0, "R5 latch off stays low", lat_cnt, 0);
      end

      // R4 pixel gap sweep
      pgap_en_i = 1;
      for (int n = 0; n <= 5; n++) begin
         pgap_n_i = 8'(n);
         frame(4, 32'h2000 + 32'(n * 16));
         check_data(4, 32'h2000 + 32'(n * 16), "R4");
         check_spacing(n + 3, "R4 gap spacing");
      end
      pgap_en_i = 0;

      // R5 R6 latch sweep
      latch_en_i = 1;
      for (int n = 0; n <= 5; n++) begin
         latch_n_i = 13'(n);
         frame(2, 32'h3000);
         chk(lat_cnt == n + 1, "R5 latch length", lat_cnt, n + 1);
         chk(sts_o[0] == 1'b1, "R6 done after latch", sts_o[0], 1);
         chk(fg_cnt == 0, "R7 no frame gap", fg_cnt, 0);
      end

      // R7 frame gap sweep, latch on then off
      fgap_en_i = 1;
      for (int n = 0; n <= 6; n += 3) begin
         fgap_n_i = 31'(n);
         frame(2, 32'h4000);
         chk(fg_cnt == n + 1, "R7 frame gap after latch", fg_cnt, n + 1);
      end
      latch_en_i = 0;
      fgap_n_i = 31'd4;
      frame(3, 32'h4100);
      chk(fg_cnt == 5, "R7 frame gap without latch", fg_cnt, 5);
      fgap_en_i = 0;

      // R3 zero length ignored
      set_len(3);
      set_len(0);
      for (int k = 0; k < 5; k++) push(32'h5000 + 32'(k));
      go_frame();
      wait_idle();
      check_data(3, 32'h5000, "R3");
      pulse_soft();

      // R8 starve sweep, each aborted by R13 soft reset
      for (int n = 0; n <= 4; n++) begin
         wait_n_i = 13'(n);
         set_len(2);
         go_frame();
         repeat (n + 8) step();
         chk(to_cyc - go_set == n + 2, "R8 starve timing", to_cyc - go_set, n + 2);
         pulse_soft();
         chk(!active_o, "R13 abort to idle", active_o, 0);
      end
      wait_n_i = 13'h1FFF;

      // R13 flush
      for (int k = 0; k < 3; k++) push(32'hDEAD0000 + 32'(k));
      pulse_soft();
      frame(1, 32'h6000);
      check_data(1, 32'h6000, "R13 flushed FIFO");

      // R9 R11 R12 overflow, clear priority, interrupt gating
      sts_clr_i = 4'hF; step(); sts_clr_i = 0;
      for (int k = 0; k < 32; k++) push(32'h7000 + 32'(k));
      chk(sts_o[2] == 1'b0, "R9 no overflow at depth", sts_o[2], 0);
      wr_valid_i = 1; wr_data_i = 32'hBAD0BAD0; sts_clr_i = 4'b0100;
      step();
      wr_valid_i = 0; sts_clr_i = 0;
      chk(sts_o[2] == 1'b1, "R11 set wins over clear", sts_o[2], 1);
      irq_mask_i = 4'b0100; irq_glob_en_i = 1; #1;
      chk(irq_o == 1'b1, "R12 enabled source", irq_o, 1);
      irq_glob_en_i = 0; #1;
      chk(irq_o == 1'b0, "R12 global off", irq_o, 0);
      irq_glob_en_i = 1; irq_mask_i = 4'b1011; #1;
      chk(irq_o == 1'b0, "R12 masked source", irq_o, 0);
      irq_mask_i = 0; irq_glob_en_i = 0;
      sts_clr_i = 4'b0100; step(); sts_clr_i = 0;
      chk(sts_o[2] == 1'b0, "R11 clear alone", sts_o[2], 0);
      set_len(32);
      go_frame();
      wait_idle();
      check_data(32, 32'h7000, "R9 dropped word absent");
      chk(sts_o[3] == 1'b0, "R10 no refill when all stored", sts_o[3], 0);

      // R10 CPU refill then DMA refill
      for (int m = 0; m < 2; m++) begin
         dma_mode_i = m[0];
         set_len(24);
         for (int k = 0; k < 20; k++) push(32'h8000 + 32'(k));
         go_frame();
         seen = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (m == 0 ? sts_o[3] : dma_req_o) begin seen = 1; break; end
         end
         chk(seen == 1'b1, m == 0 ? "R10 cpu refill status" : "R10 dma request", seen, 1);
         step();
         for (int k = 20; k < 24; k++) push(32'h8000 + 32'(k));
         wait_idle();
         check_data(24, 32'h8000, "R10");
         if (m == 0) chk(dreq_seen == 0, "R10 no dma req in cpu mode", dreq_seen, 0);
         else chk(sts_o[3] == 1'b0, "R10 no refill status in dma mode", sts_o[3], 0);
         chk(dma_req_o == 1'b0, "R10 request drops when idle", dma_req_o, 0);
      end
      dma_mode_i = 0;

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule